// File: doc/BRIEF.md
# Dual-Threshold Gain Control Indicators

This block sits behind a dual pipelined converter channel. It turns the signed output samples, and a coarse 4-bit level code taken from an early converter stage, into four fast-detect pins for an external automatic gain loop. Every comparison uses the size of the sample and ignores its sign.

A coarse path compares the early level code with a small threshold. The result is stretched to a minimum width and serves as the gain-decrease request. A fine path compares the full-resolution magnitude with an upper and a lower threshold. The gain-increase request is raised only after the magnitude has stayed under the lower threshold for a programmable number of consecutive clocks. A legacy flag marks samples at full scale.

A 3-bit mode input chooses which of these indications appear on the four pins. One sample and one level code are accepted every clock. All pins respond two clocks after the input that caused the change. The mode and threshold inputs are sampled every clock, so any change to them applies from the next clock edge.

Top module: `gain_flag_gen`

## Requirements
- R1: Magnitude is |sample| (14-bit two's complement input, 13-bit magnitude). A positive and a negative sample of equal size give identical pin values in every mode.
- R2: The most negative code (-8192) has magnitude 8191, the same as +8191.
- R3: The coarse flag is computed as early_level > coarse_thr, with the threshold zero-extended to 4 bits. It appears on the pins two clock edges after the level code is presented.
- R4: Once the coarse flag is set, it stays high for at least HOLD_CYCLES (2) clocks. It stays high for longer while the compare keeps holding true. The gain-decrease flag is this held coarse flag.
- R5: The fine-upper flag is magnitude > fine_upper_thr. The fine-lower flag is magnitude < fine_lower_thr. Both appear two clocks after the sample.
- R6: The gain-increase flag rises on the pins with the D-th consecutive sample whose magnitude is below fine_lower_thr, where D = dwell_cycles. A dwell_cycles value of 0 acts as 1.
- R7: A sample with magnitude at or above fine_lower_thr restarts the dwell count. The same sample clears the gain-increase flag.
- R8: A change of fd_mode between two clocks clears the dwell count. The gain-increase flag is low at that edge, and counting resumes from the next below-threshold sample.
- R9: Mode 000 places the early level code on fd_out[3:0], two clocks after it is presented.
- R10: Pin map (fd_out[3:0]):
  - Mode 001: {lvl[3:1], coarse}
  - Mode 010: {lvl[3:2], fine_upper, coarse}
  - Mode 011: {lvl[3:2], gain_inc, gain_dec}
  - Mode 101: {fine_upper, fine_lower, gain_inc, gain_dec}
  - Modes 110 and 111: 0000
- R11: Mode 100 maps {fine_lower, fine_upper, coarse, overrange} onto fd_out[3:0]. Overrange is high when the magnitude equals 8191.
- R12: While rst is high, fd_out is 0000 and all state is cleared.
- R13: A new value on fd_mode or on any threshold is used at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sample | input | 14 | Two's-complement converter output, one per clock |
| early_level | input | 4 | Coarse level code from an early converter stage |
| coarse_thr | input | 3 | Coarse upper threshold |
| fine_upper_thr | input | 13 | Fine upper magnitude threshold |
| fine_lower_thr | input | 13 | Fine lower magnitude threshold |
| dwell_cycles | input | 16 | Consecutive below-threshold clocks needed before a gain increase |
| fd_mode | input | 3 | Fast-detect pin function select |
| fd_out | output | 4 | Fast-detect pins |

## Verification
The bench builds the block with its default parameters: 14-bit samples, a 16-bit dwell counter and a two-clock minimum hold. Full-scale codes therefore sit at ±8191 and -8192, which lets both the saturation corner and the legacy overrange flag be reached directly. The dwell register is programmed with 0, 1 and 3, so expiry, restart and a mode switch in the middle of a dwell run all happen within a few clocks. A pseudo-random run over all eight modes then compares every pin against a reference model computed in the bench.

// File: rtl/gci_pkg.sv
package gci_pkg;

    localparam int FD_PINS = 4;

    typedef enum logic [2:0] {
        FD_RAW       = 3'b000,
        FD_COARSE    = 3'b001,
        FD_UPPER     = 3'b010,
        FD_AGC_LVL   = 3'b011,
        FD_THRESH    = 3'b100,
        FD_AGC_FINE  = 3'b101,
        FD_QUIET6    = 3'b110,
        FD_QUIET7    = 3'b111
    } fd_mode_e;

    typedef struct packed {
        logic gain_inc;
        logic gain_dec;
        logic fine_low;
        logic fine_high;
        logic ovr;
    } ind_flags_s;

    function automatic logic [FD_PINS-1:0] fd_select(
        input fd_mode_e          mode,
        input ind_flags_s        fl,
        input logic [FD_PINS-1:0] lvl
    );
        logic [FD_PINS-1:0] pins;
        unique case (mode)
            FD_RAW:      pins = lvl;
            FD_COARSE:   pins = {lvl[3:1], fl.gain_dec};
            FD_UPPER:    pins = {lvl[3:2], fl.fine_high, fl.gain_dec};
            FD_AGC_LVL:  pins = {lvl[3:2], fl.gain_inc, fl.gain_dec};
            FD_THRESH:   pins = {fl.fine_low, fl.fine_high, fl.gain_dec, fl.ovr};
            FD_AGC_FINE: pins = {fl.fine_high, fl.fine_low, fl.gain_inc, fl.gain_dec};
            default:     pins = '0;
        endcase
        return pins;
    endfunction

endpackage

// File: rtl/gci_front.sv
module gci_front #(
    parameter int SAMPLE_W = 14,
    parameter int LEVEL_W  = 4,
    parameter int CTHR_W   = 3,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [LEVEL_W-1:0]  level_i,
    input  logic [CTHR_W-1:0]   cthr_i,
    output logic [MAG_W-1:0]    mag_q,
    output logic [LEVEL_W-1:0]  level_q,
    output logic                over_q
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [SAMPLE_W-1:0] negated;
    logic [MAG_W-1:0]    mag_nx;

    always_comb begin
        negated = ~sample_i + 1'b1;
        if (!sample_i[SAMPLE_W-1])
            mag_nx = sample_i[MAG_W-1:0];
        else if (negated[SAMPLE_W-1])
            mag_nx = '1;
        else
            mag_nx = negated[MAG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q   <= '0;
            level_q <= '0;
            over_q  <= 1'b0;
        end else begin
            mag_q   <= mag_nx;
            level_q <= level_i;
            over_q  <= level_i > LEVEL_W'(cthr_i);
        end
    end

    assert_most_neg_sat_R2: assert property (@(posedge clk) disable iff (rst)
        (sample_i == MOST_NEG) |=> (mag_q == {MAG_W{1'b1}}));

    assert_positive_passthru_R1: assert property (@(posedge clk) disable iff (rst)
        (!sample_i[SAMPLE_W-1]) |=> (mag_q == $past(sample_i[MAG_W-1:0])));

endmodule

// File: rtl/gci_hold.sv
module gci_hold #(
    parameter int HOLD_CYCLES = 2,
    localparam int HC_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic over_i,
    output logic held_nx_o
);
    logic [HC_W-1:0] remain_q;
    logic [HC_W-1:0] remain_nx;
    logic            held_q;

    always_comb begin
        held_nx_o = over_i || (remain_q != '0);
        if (over_i)
            remain_nx = HC_W'(HOLD_CYCLES - 1);
        else if (remain_q != '0)
            remain_nx = remain_q - 1'b1;
        else
            remain_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            held_q   <= 1'b0;
        end else begin
            remain_q <= remain_nx;
            held_q   <= held_nx_o;
        end
    end

    assert_min_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(held_q) |=> held_q);

endmodule

// File: rtl/gci_dwell.sv
module gci_dwell #(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               below_i,
    input  logic [2:0]         mode_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output logic               gain_inc_nx_o
);
    logic [DWELL_W-1:0] count_q;
    logic [DWELL_W-1:0] count_nx;
    logic [DWELL_W-1:0] target;
    logic [2:0]         mode_q;
    logic               inc_q;

    always_comb begin
        target = (dwell_i == '0) ? DWELL_W'(1) : dwell_i;
        if ((mode_i != mode_q) || !below_i) begin
            count_nx      = '0;
            gain_inc_nx_o = 1'b0;
        end else begin
            count_nx      = (count_q >= target) ? count_q : count_q + 1'b1;
            gain_inc_nx_o = count_nx >= target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            mode_q  <= '0;
            inc_q   <= 1'b0;
        end else begin
            count_q <= count_nx;
            mode_q  <= mode_i;
            inc_q   <= gain_inc_nx_o;
        end
    end

    assert_restart_drop_R7: assert property (@(posedge clk) disable iff (rst)
        !below_i |=> !inc_q);

    assert_mode_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_i != mode_q) |=> (count_q == '0));

    assert_inc_needs_count_R6: assert property (@(posedge clk) disable iff (rst)
        inc_q |-> (count_q != '0));

endmodule

// File: rtl/gain_flag_gen.sv
module gain_flag_gen
    import gci_pkg::*;
#(
    parameter int SAMPLE_W    = 14,
    parameter int CTHR_W      = 3,
    parameter int DWELL_W     = 16,
    parameter int HOLD_CYCLES = 2,
    localparam int MAG_W      = SAMPLE_W - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] adc_sample,
    input  logic [FD_PINS-1:0]  early_level,
    input  logic [CTHR_W-1:0]   coarse_thr,
    input  logic [MAG_W-1:0]    fine_upper_thr,
    input  logic [MAG_W-1:0]    fine_lower_thr,
    input  logic [DWELL_W-1:0]  dwell_cycles,
    input  logic [2:0]          fd_mode,
    output logic [FD_PINS-1:0]  fd_out
);
    logic [MAG_W-1:0]   mag_s1;
    logic [FD_PINS-1:0] lvl_s1;
    logic               over_s1;
    logic               coarse_held;
    logic               gain_inc;
    ind_flags_s         flags;

    gci_front #(
        .SAMPLE_W(SAMPLE_W),
        .LEVEL_W (FD_PINS),
        .CTHR_W  (CTHR_W)
    ) u_front (
        .clk     (clk),
        .rst     (rst),
        .sample_i(adc_sample),
        .level_i (early_level),
        .cthr_i  (coarse_thr),
        .mag_q   (mag_s1),
        .level_q (lvl_s1),
        .over_q  (over_s1)
    );

    gci_hold #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .over_i   (over_s1),
        .held_nx_o(coarse_held)
    );

    gci_dwell #(
        .DWELL_W(DWELL_W)
    ) u_dwell (
        .clk          (clk),
        .rst          (rst),
        .below_i      (mag_s1 < fine_lower_thr),
        .mode_i       (fd_mode),
        .dwell_i      (dwell_cycles),
        .gain_inc_nx_o(gain_inc)
    );

    always_comb begin
        flags.gain_inc  = gain_inc;
        flags.gain_dec  = coarse_held;
        flags.fine_low  = mag_s1 < fine_lower_thr;
        flags.fine_high = mag_s1 > fine_upper_thr;
        flags.ovr       = &mag_s1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fd_out <= '0;
        else
            fd_out <= fd_select(fd_mode_e'(fd_mode), flags, lvl_s1);
    end

    assert_raw_level_R9: assert property (@(posedge clk) disable iff (rst)
        (fd_mode == 3'b000) |=> (fd_out == $past(lvl_s1)));

    assert_coarse_fast_R3: assert property (@(posedge clk) disable iff (rst)
        (over_s1 && fd_mode == 3'b001) |=> fd_out[0]);

    assert_quiet_modes_R10: assert property (@(posedge clk) disable iff (rst)
        (fd_mode[2:1] == 2'b11) |=> (fd_out == '0));

endmodule

// File: tb/gain_flag_gen_test.sv
module gain_flag_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] adc_sample = '0;
    logic [3:0]  early_level = '0;
    logic [2:0]  coarse_thr = 3'd3;
    logic [12:0] fine_upper_thr = 13'd4000;
    logic [12:0] fine_lower_thr = 13'd100;
    logic [15:0] dwell_cycles = 16'd3;
    logic [2:0]  fd_mode = 3'd0;
    logic [3:0]  fd_out;

    always #5 clk = ~clk;

    gain_flag_gen uut (
        .clk           (clk),
        .rst           (rst),
        .adc_sample    (adc_sample),
        .early_level   (early_level),
        .coarse_thr    (coarse_thr),
        .fine_upper_thr(fine_upper_thr),
        .fine_lower_thr(fine_lower_thr),
        .dwell_cycles  (dwell_cycles),
        .fd_mode       (fd_mode),
        .fd_out        (fd_out)
    );

    // configuration shadows, applied at the next step
    int c_thr = 3, c_hi = 4000, c_lo = 100, c_dwell = 3, c_mode = 0;

    // reference model state
    int m_mag = 0, m_lvl = 0, m_over = 0, m_cu_hold = 0, m_cnt = 0, m_mode_last = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];
    int checks = 0, fails = 0;
    logic [31:0] rnd = 32'h1d872b41;

    function automatic int mag_of(int s);
        if (s < 0) begin
            if (s == -8192) return 8191;
            return -s;
        end
        return s;
    endfunction

    task automatic step(input int s, input int lvl, input string tag);
        int below, fu, fl, ovr, gi, gd, deff;
        logic [3:0] l4, e;
        @(negedge clk);
        adc_sample     = s[13:0];
        early_level    = lvl[3:0];
        coarse_thr     = c_thr[2:0];
        fine_upper_thr = c_hi[12:0];
        fine_lower_thr = c_lo[12:0];
        dwell_cycles   = c_dwell[15:0];
        fd_mode        = c_mode[2:0];
        // output of the coming edge, from the previous input and current config
        below = (m_mag < c_lo) ? 1 : 0;
        fl = below;
        fu = (m_mag > c_hi) ? 1 : 0;
        ovr = (m_mag == 8191) ? 1 : 0;
        deff = (c_dwell == 0) ? 1 : c_dwell;
        if (c_mode != m_mode_last || below == 0) begin
            m_cnt = 0; gi = 0;
        end else begin
            if (m_cnt < deff) m_cnt++;
            gi = (m_cnt >= deff) ? 1 : 0;
        end
        gd = (m_over != 0 || m_cu_hold > 0) ? 1 : 0;
        if (m_over != 0) m_cu_hold = 1;
        else if (m_cu_hold > 0) m_cu_hold--;
        l4 = m_lvl[3:0];
        case (c_mode)
            0: e = l4;
            1: e = {l4[3:1], gd[0]};
            2: e = {l4[3:2], fu[0], gd[0]};
            3: e = {l4[3:2], gi[0], gd[0]};
            4: e = {fl[0], fu[0], gd[0], ovr[0]};
            5: e = {fu[0], fl[0], gi[0], gd[0]};
            default: e = 4'b0000;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        m_mode_last = c_mode;
        m_mag = mag_of(s);
        m_lvl = lvl;
        m_over = (lvl > c_thr) ? 1 : 0;
    endtask

    // monitor: compares just after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (fd_out !== e) begin
                fails++;
                $display("FAIL %s: fd_out=%b expected=%b at %0t", t, fd_out, e, $time);
            end
        end
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R12: pins stay clear during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            adc_sample = 14'd8191; early_level = 4'hF;
            checks++;
            if (fd_out !== 4'b0000) begin
                fails++;
                $display("FAIL R12: fd_out=%b expected=0000", fd_out);
            end
        end
        adc_sample = '0; early_level = '0;
        @(negedge clk);
        rst = 1'b0;

        // R9: raw level on all pins
        c_mode = 0;
        for (int k = 0; k < 16; k++) step(0, k, "R9");
        step(0, 0, "R9");

        // R3 / R4: coarse compare, latency and minimum hold
        c_mode = 1;
        step(0, 2, "R3");
        step(0, 7, "R3");
        step(0, 1, "R4");
        step(0, 1, "R4");
        step(0, 1, "R4");
        step(0, 9, "R4");
        step(0, 9, "R4");
        step(0, 9, "R4");
        step(0, 0, "R4");
        step(0, 0, "R4");
        step(0, 0, "R4");
        step(0, 4, "R3");
        step(0, 3, "R3");
        step(0, 3, "R3");
        // R13: threshold change used at the next edge
        c_thr = 6; step(0, 7, "R13");
        c_thr = 7; step(0, 7, "R13");
        step(0, 7, "R13");
        step(0, 8, "R13");
        step(0, 0, "R13");
        step(0, 0, "R13");
        c_thr = 3;

        // R5 / R1 / R2 / R11: fine compares and overrange
        c_mode = 4;
        step(5000, 0, "R5");
        step(-5000, 0, "R1");
        step(4000, 0, "R5");
        step(-4000, 0, "R1");
        step(4001, 0, "R5");
        step(-4001, 0, "R1");
        step(99, 0, "R5");
        step(-99, 0, "R1");
        step(100, 0, "R5");
        step(-100, 0, "R1");
        step(8191, 0, "R11");
        step(-8191, 0, "R11");
        step(-8192, 0, "R2");
        step(8190, 0, "R11");
        step(0, 5, "R11");
        c_hi = 50; step(60, 0, "R13");
        c_lo = 70; step(60, 0, "R13");
        step(60, 0, "R13");
        c_hi = 4000; c_lo = 100;

        // R6 / R7: dwell timer
        c_mode = 5; c_dwell = 3;
        step(0, 0, "R8");
        for (int k = 0; k < 6; k++) step((k % 2) ? -10 : 10, 0, "R6");
        step(100, 0, "R7");
        step(10, 0, "R7");
        step(-10, 0, "R7");
        step(10, 0, "R6");
        step(-100, 0, "R7");
        step(10, 0, "R7");
        step(10, 0, "R7");
        step(10, 0, "R6");
        step(10, 0, "R6");
        c_dwell = 0;
        step(10, 0, "R6");
        step(200, 0, "R7");
        step(10, 0, "R6");
        step(10, 0, "R6");
        c_dwell = 1;
        step(10, 0, "R6");
        step(10, 0, "R6");
        c_dwell = 5;
        step(10, 0, "R6");
        step(10, 0, "R6");

        // R8: mode switch during a dwell run
        c_dwell = 2;
        for (int k = 0; k < 4; k++) step(10, 12, "R8");
        c_mode = 3;
        for (int k = 0; k < 4; k++) step(10, 12, "R8");
        c_mode = 5;
        for (int k = 0; k < 4; k++) step(-10, 9, "R8");

        // R10: other maps
        c_mode = 2;
        step(5000, 15, "R10");
        step(10, 4, "R10");
        step(0, 0, "R10");
        c_mode = 6;
        step(8191, 15, "R10");
        step(-8192, 15, "R10");
        c_mode = 7;
        step(3, 15, "R10");
        step(3, 0, "R10");

        // R10 / R1: pseudo-random sweep across modes and thresholds
        for (int k = 0; k < 400; k++) begin
            int s;
            rnd = rnd ^ (rnd << 13);
            rnd = rnd ^ (rnd >> 17);
            rnd = rnd ^ (rnd << 5);
            s = int'($signed(rnd[13:0]));
            if (rnd[31:30] == 2'b00) s = s / 128;
            if ((k % 25) == 0) c_mode = int'(rnd[18:16]);
            if ((k % 40) == 0) c_thr = int'(rnd[21:19]);
            if ((k % 60) == 0) c_dwell = int'(rnd[23:22]);
            if ((k % 50) == 0) c_lo = 64 + int'(rnd[27:24]) * 16;
            step(s, int'(rnd[29:26]), "R10");
        end

        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule